// File: doc/BRIEF.md
# Slot-Table Memory Arbiter

This block shares one memory port among up to fourteen requesting clients by time division. Two memory regions (external and internal) each get their own scheduler, with its own request vector, grant vector, completion strobe and a private table of 64 slot entries. Every entry names the client that owns that slot. A region's scheduler looks at the entry under its slot pointer. If the named client is requesting, that client receives the grant. If it is not, the slot is handed to the lowest-numbered client that is requesting. This fallback lets clients that hold no slots, such as processor caches, still reach memory.

The grant behaves like a valid signal and the completion strobe like its ready signal. A grant, once issued, stays asserted and unchanged until the client pulses `done` for that region. The cycle in which `done` is sampled high with a grant present ends the access and moves the pointer to the next slot. While nobody requests, the pointer steps once per cycle, so the schedule keeps rotating. Requests are sampled only while the region is idle. A client drops its request once it sees its grant. Software fills the tables through a single write port that selects the region, the slot and the client number.

Top module: `slot_arbiter`

## Requirements
- R1: After reset, every grant is low, both slot pointers read 0, and every table entry of both regions names client 0.
- R2: When a region is idle and the client named by the current entry is requesting, that client is granted one cycle later with `gnt_fb` low, whichever other clients also request.
- R3: When the named client is not requesting, the lowest-numbered requesting client is granted one cycle later with `gnt_fb` high. Clients 10 and 11 are reachable this way.
- R4: An entry holding a value of 14 or 15 names no client, so that slot always goes through the fallback of R3.
- R5: Each region's grant vector has at most one bit set (bit i is client i). It stays unchanged from issue until the cycle in which `done` is sampled high.
- R6: `done` sampled high during a grant clears the grant and advances the pointer by one, wrapping from slot 63 to slot 0. While the grant is waiting for `done`, the pointer holds.
- R7: A region that is idle with no request keeps its grant low and advances its pointer by one every cycle.
- R8: `done` while a region is idle has no effect: a request sampled in that same cycle is still granted and held, and the pointer steps only once.
- R9: A table write to the slot that is currently granted leaves the grant in progress unchanged. The new owner applies on the next visit to that slot.
- R10: The regions are independent. A write with `tbl_region` = 1 changes only region 1's table, and one region's pointer keeps moving while the other region holds a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 28 | Requests, region r clients at bits [r*14 +: 14] |
| done | input | 2 | Access-complete strobe per region (ready for the grant) |
| gnt | output | 28 | One-hot grant per region, same layout as `req` |
| gnt_fb | output | 2 | High when the region's grant came from the fallback |
| slot_ptr | output | 12 | Current slot per region, region r at bits [r*6 +: 6] |
| tbl_we | input | 1 | Table write enable |
| tbl_region | input | 1 | Table write region select (0 external, 1 internal) |
| tbl_slot | input | 6 | Table write slot index |
| tbl_client | input | 4 | Client number to store (14 and 15 mean no owner) |

## Verification
The hardest cases to set up from the ports need a particular slot under the pointer, because the pointer runs freely whenever a region is idle. The bench watches `slot_ptr` at each falling edge. When the chosen slot comes up, it raises the request in that same half cycle, so the next rising edge evaluates exactly that entry. The same method returns to a slot after rewriting it in the middle of an access, which shows that the old grant was kept and that the new owner applies on the following visit. It also reaches the wrap from slot 63 to slot 0.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int DEF_CLIENTS = 14;
  localparam int DEF_SLOTS   = 64;
  localparam int DEF_REGIONS = 2;

  typedef enum logic {
    SRC_OWNER    = 1'b0,
    SRC_FALLBACK = 1'b1
  } gnt_src_e;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int NUM_SLOTS = 64,
  parameter int CIDX_W    = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [CIDX_W-1:0] wr_client,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [CIDX_W-1:0] rd_client
);
  logic [CIDX_W-1:0] entry_q [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) entry_q[s] <= '0;
    end else if (we) begin
      entry_q[wr_slot] <= wr_client;
    end
  end

  assign rd_client = entry_q[rd_slot];
endmodule

// File: rtl/fallback_pick.sv
module fallback_pick #(
  parameter int N      = 14,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/region_sched.sv
module region_sched
  import slot_arb_pkg::*;
#(
  parameter int NUM_CLIENTS = 14,
  parameter int NUM_SLOTS   = 64,
  localparam int CIDX_W     = $clog2(NUM_CLIENTS),
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int LAST_SLOT  = NUM_SLOTS - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLIENTS-1:0] req,
  input  logic                   done,
  input  logic [CIDX_W-1:0]      owner,
  output logic [SLOT_W-1:0]      ptr,
  output logic [NUM_CLIENTS-1:0] gnt,
  output logic                   gnt_fb
);
  logic                   busy_q;
  logic [NUM_CLIENTS-1:0] gnt_q;
  gnt_src_e               src_q;
  logic [SLOT_W-1:0]      ptr_q;
  logic [SLOT_W-1:0]      ptr_nxt;
  logic                   owner_hit;
  logic [CIDX_W-1:0]      fb_idx;
  logic                   fb_any;

  always_comb begin
    owner_hit = 1'b0;
    for (int i = 0; i < NUM_CLIENTS; i++) begin
      if (owner == CIDX_W'(i) && req[i]) owner_hit = 1'b1;
    end
  end

  fallback_pick #(.N(NUM_CLIENTS)) u_pick (
    .cand (req),
    .idx  (fb_idx),
    .any  (fb_any)
  );

  assign ptr_nxt = (ptr_q == SLOT_W'(LAST_SLOT)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gnt_q  <= '0;
      src_q  <= SRC_OWNER;
      ptr_q  <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        gnt_q  <= '0;
        src_q  <= SRC_OWNER;
        ptr_q  <= ptr_nxt;
      end
    end else if (owner_hit) begin
      busy_q <= 1'b1;
      gnt_q  <= NUM_CLIENTS'(1) << owner;
      src_q  <= SRC_OWNER;
    end else if (fb_any) begin
      busy_q <= 1'b1;
      gnt_q  <= NUM_CLIENTS'(1) << fb_idx;
      src_q  <= SRC_FALLBACK;
    end else begin
      ptr_q  <= ptr_nxt;
    end
  end

  assign ptr    = ptr_q;
  assign gnt    = gnt_q;
  assign gnt_fb = (src_q == SRC_FALLBACK);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R5
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !done) |=> (gnt != '0 && $stable(gnt) && $stable(ptr))); // R6
  AST_OWNER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && owner_hit) |=> (!gnt_fb && gnt != '0)); // R2
  AST_FB_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !owner_hit && req != '0) |=>
      (gnt_fb && (gnt & $past(req)) != '0 && ((gnt - 1'b1) & $past(req)) == '0)); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && done) |=>
      (gnt == '0 && ptr == (($past(ptr) == SLOT_W'(LAST_SLOT)) ? '0 : $past(ptr) + 1'b1))); // R6
  AST_IDLE_SPIN: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req == '0) |=>
      (gnt == '0 && ptr == (($past(ptr) == SLOT_W'(LAST_SLOT)) ? '0 : $past(ptr) + 1'b1))); // R7
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && done && req != '0) |=> (gnt != '0 && $stable(ptr))); // R8
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int NUM_CLIENTS = DEF_CLIENTS,
  parameter int NUM_SLOTS   = DEF_SLOTS,
  parameter int NUM_REGIONS = DEF_REGIONS,
  localparam int CIDX_W     = $clog2(NUM_CLIENTS),
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int RGN_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_REGIONS*NUM_CLIENTS-1:0] req,
  input  logic [NUM_REGIONS-1:0]             done,
  output logic [NUM_REGIONS*NUM_CLIENTS-1:0] gnt,
  output logic [NUM_REGIONS-1:0]             gnt_fb,
  output logic [NUM_REGIONS*SLOT_W-1:0]      slot_ptr,
  input  logic                               tbl_we,
  input  logic [RGN_W-1:0]                   tbl_region,
  input  logic [SLOT_W-1:0]                  tbl_slot,
  input  logic [CIDX_W-1:0]                  tbl_client
);
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic              we_r;
    logic [SLOT_W-1:0] ptr_r;
    logic [CIDX_W-1:0] owner_r;

    assign we_r = tbl_we && (tbl_region == RGN_W'(r));

    slot_table #(.NUM_SLOTS(NUM_SLOTS), .CIDX_W(CIDX_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (we_r),
      .wr_slot   (tbl_slot),
      .wr_client (tbl_client),
      .rd_slot   (ptr_r),
      .rd_client (owner_r)
    );

    region_sched #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SLOTS(NUM_SLOTS)) u_sched (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req[r*NUM_CLIENTS +: NUM_CLIENTS]),
      .done   (done[r]),
      .owner  (owner_r),
      .ptr    (ptr_r),
      .gnt    (gnt[r*NUM_CLIENTS +: NUM_CLIENTS]),
      .gnt_fb (gnt_fb[r])
    );

    assign slot_ptr[r*SLOT_W +: SLOT_W] = ptr_r;
  end
endmodule

// File: tb/test_slot_arbiter.sv
module test_slot_arbiter;
  localparam int NC = 14;
  localparam int NS = 64;
  localparam int NR = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NR*NC-1:0] req = '0;
  logic [NR-1:0]    done = '0;
  logic [NR*NC-1:0] gnt;
  logic [NR-1:0]    gnt_fb;
  logic [NR*6-1:0]  slot_ptr;
  logic            tbl_we = 1'b0;
  logic [0:0]      tbl_region = '0;
  logic [5:0]      tbl_slot = '0;
  logic [3:0]      tbl_client = '0;

  slot_arbiter i_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .gnt(gnt),
    .gnt_fb(gnt_fb), .slot_ptr(slot_ptr), .tbl_we(tbl_we),
    .tbl_region(tbl_region), .tbl_slot(tbl_slot), .tbl_client(tbl_client)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    rg;
    int    cl;
    bit    fb;
    int    slot;
    string tag;
  } exp_t;
  exp_t q[$];

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  function automatic int ptr_of(int rg);
    return int'(slot_ptr[rg*6 +: 6]);
  endfunction

  function automatic logic [NC-1:0] g_of(int rg);
    return gnt[rg*NC +: NC];
  endfunction

  function automatic int gidx(logic [NC-1:0] g);
    int k = -1;
    for (int i = 0; i < NC; i++) if (g[i]) k = i;
    return k;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops an expected item at every new grant
  initial begin
    logic [NR*NC-1:0] prev;
    prev = '0;
    forever begin
      @(negedge clk);
      for (int rg = 0; rg < NR; rg++) begin
        if (gnt[rg*NC +: NC] != '0 && prev[rg*NC +: NC] == '0) begin
          if (q.size() == 0) begin
            chk(0, "R5", "unexpected grant", gidx(g_of(rg)), -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.rg == rg, e.tag, "grant region", rg, e.rg);
            chk(gidx(g_of(rg)) == e.cl, e.tag, "granted client", gidx(g_of(rg)), e.cl);
            chk(gnt_fb[rg] == e.fb, e.tag, "fallback flag", int'(gnt_fb[rg]), int'(e.fb));
            chk(ptr_of(rg) == e.slot, e.tag, "slot at grant", ptr_of(rg), e.slot);
          end
        end
      end
      prev = gnt;
    end
  end

  task automatic twrite(int rg, int s, int c);
    tbl_we = 1'b1;
    tbl_region = 1'(rg);
    tbl_slot = 6'(s);
    tbl_client = 4'(c);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic wait_slot(int rg, int s);
    while (ptr_of(rg) != s) @(negedge clk);
  endtask

  task automatic push(int rg, int cl, bit fb, int slot, string tag);
    exp_t e;
    e.rg = rg; e.cl = cl; e.fb = fb; e.slot = slot; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: one access, entered and left at a falling edge
  task automatic access(int rg, logic [NC-1:0] rv, int hold, int ecl, bit efb, string tag);
    int p;
    p = ptr_of(rg);
    push(rg, ecl, efb, p, tag);
    req[rg*NC +: NC] = rv;
    @(negedge clk);
    req[rg*NC +: NC] = '0;
    chk(g_of(rg) != '0, tag, "grant issued", gidx(g_of(rg)), ecl);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(gidx(g_of(rg)) == ecl, "R5", "grant held", gidx(g_of(rg)), ecl);
      chk(ptr_of(rg) == p, "R6", "pointer held", ptr_of(rg), p);
    end
    done[rg] = 1'b1;
    @(negedge clk);
    done[rg] = 1'b0;
    chk(g_of(rg) == '0, "R6", "grant released", gidx(g_of(rg)), -1);
    chk(ptr_of(rg) == (p + 1) % NS, "R6", "pointer step", ptr_of(rg), (p + 1) % NS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    chk(gnt == '0, "R1", "grant in reset", int'(gnt != '0), 0);
    chk(ptr_of(0) == 0 && ptr_of(1) == 0, "R1", "pointers in reset", ptr_of(0) + ptr_of(1), 0);
    rst_n = 1'b1;

    // R1: default table names client 0 everywhere
    access(0, 14'h0009, 0, 0, 1'b0, "R1");
    access(0, 14'h0020, 0, 5, 1'b1, "R3");
    access(1, 14'h0009, 0, 0, 1'b0, "R1");

    // R2: owner 12 beats lower requesters, grant held 3 cycles
    twrite(0, 10, 12);
    wait_slot(0, 10);
    access(0, 14'h1804, 3, 12, 1'b0, "R2");

    // R3: caches 10/11 reachable via fallback
    twrite(0, 20, 7);
    wait_slot(0, 20);
    access(0, 14'h0C00, 1, 10, 1'b1, "R3");

    // R4: entry 15 names nobody
    twrite(0, 30, 15);
    wait_slot(0, 30);
    access(0, 14'h2200, 0, 9, 1'b1, "R4");
    twrite(0, 31, 14);
    wait_slot(0, 31);
    access(0, 14'h2000, 0, 13, 1'b1, "R4");

    // R7: idle spin
    p = ptr_of(0);
    @(negedge clk);
    chk(ptr_of(0) == (p + 1) % NS, "R7", "idle step", ptr_of(0), (p + 1) % NS);
    chk(g_of(0) == '0, "R7", "no idle grant", gidx(g_of(0)), -1);

    // R8: done while idle without request steps once
    p = ptr_of(0);
    done[0] = 1'b1;
    @(negedge clk);
    done[0] = 1'b0;
    chk(ptr_of(0) == (p + 1) % NS, "R8", "idle done step", ptr_of(0), (p + 1) % NS);

    // R8: done with request in the idle cycle is ignored
    wait_slot(0, 40);
    push(0, 3, 1'b1, 40, "R8");
    req[3] = 1'b1;
    done[0] = 1'b1;
    @(negedge clk);
    req[3] = 1'b0;
    done[0] = 1'b0;
    chk(ptr_of(0) == 40, "R8", "pointer after idle done", ptr_of(0), 40);
    @(negedge clk);
    chk(gidx(g_of(0)) == 3, "R8", "grant survives idle done", gidx(g_of(0)), 3);
    done[0] = 1'b1;
    @(negedge clk);
    done[0] = 1'b0;
    chk(ptr_of(0) == 41, "R8", "pointer after real done", ptr_of(0), 41);

    // R9: rewrite the granted slot mid-access
    wait_slot(0, 50);
    push(0, 1, 1'b1, 50, "R9");
    req[NC-1:0] = 14'h0102;
    @(negedge clk);
    req[NC-1:0] = '0;
    twrite(0, 50, 8);
    chk(gidx(g_of(0)) == 1, "R9", "grant kept after write", gidx(g_of(0)), 1);
    chk(gnt_fb[0] == 1'b1, "R9", "source kept after write", int'(gnt_fb[0]), 1);
    done[0] = 1'b1;
    @(negedge clk);
    done[0] = 1'b0;
    wait_slot(0, 50);
    access(0, 14'h0102, 0, 8, 1'b0, "R9");

    // R6: wrap 63 -> 0
    wait_slot(0, 63);
    access(0, 14'h0040, 0, 6, 1'b1, "R6");

    // R10: region independence
    twrite(1, 5, 4);
    wait_slot(0, 5);
    p = ptr_of(1);
    access(0, 14'h0011, 2, 0, 1'b0, "R10");
    chk(ptr_of(1) == (p + 4) % NS, "R10", "other region spins", ptr_of(1), (p + 4) % NS);
    wait_slot(1, 5);
    access(1, 14'h0011, 0, 4, 1'b0, "R10");

    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R5", "all grants seen", q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule